// File: doc/BRIEF.md
# Audio Sample FIFO with Coarse Fill Classification

This block is a synchronous sample buffer that sits between a serial audio shifter and the system side of an audio port. Samples enter through a valid/ready push port and leave in arrival order through a valid/ready pop port. Alongside the usual full and empty flags, it reports a 3-bit coarse fill class. Software or a DMA engine uses this class to decide how much room or how much data is left without reading an exact count.

The class splits occupancy into quarters of the depth. A direction input selects how an occupancy that lands exactly on a quarter boundary is classed. When transmitting, a boundary value falls into the lower class. When receiving, it falls into the upper class. The class is held in a register that is loaded from the occupancy and direction present before each clock edge. A synchronous clear drops all stored samples and resets the class.

Top module: `audio_fifo_lvl`

## Requirements
- R1: A sample is written when `push_valid` is high and the FIFO is not full; `push_ready` equals the inverse of `full`, and a push offered while full leaves the stored contents untouched.
- R2: `pop_valid` is high whenever the FIFO holds a sample, and `pop_data` always shows the oldest stored sample; a pop is taken when `pop_valid` and `pop_ready` are both high.
- R3: `empty` is high exactly when occupancy is 0 and `full` is high exactly when occupancy equals `DEPTH`; occupancy never exceeds `DEPTH`.
- R4: In a cycle where both a push and a pop are taken, occupancy is unchanged and the sample order is preserved.
- R5: The level code is 0 (binary 000) for occupancy 0 and 5 (binary 101) for occupancy `DEPTH`, in either direction.
- R6: With `dir_rx` = 0 (transmit), for occupancy n with 0 < n < `DEPTH` and Q = `DEPTH`/4, the code is 1 for n <= Q, 2 for Q < n <= 2Q, 3 for 2Q < n <= 3Q, and 4 for n > 3Q.
- R7: With `dir_rx` = 1 (receive), for occupancy n with 0 < n < `DEPTH`, the code is 1 for n < Q, 2 for Q <= n < 2Q, 3 for 2Q <= n < 3Q, and 4 for n >= 3Q.
- R8: At each clock edge the level register loads the class of the occupancy and `dir_rx` seen before that edge, so the code trails `full`/`empty` by one cycle.
- R9: The level code never takes the values 6 or 7.
- R10: A synchronous `clear` empties the FIFO and sets the level code to 0 at the same edge, taking priority over any push or pop offered in that cycle; reset has the same effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous flush of all stored samples |
| dir_rx | input | 1 | Level classing mode: 0 transmit, 1 receive |
| push_valid | input | 1 | Write side offers a sample |
| push_ready | output | 1 | FIFO can take a sample |
| push_data | input | DATA_W | Sample to write |
| pop_valid | output | 1 | FIFO holds a sample |
| pop_ready | input | 1 | Read side takes the head sample |
| pop_data | output | DATA_W | Oldest stored sample |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |
| level | output | 3 | Registered coarse fill class |

## Verification
The hardest cases to reach are the exact quarter occupancies (Q, 2Q, 3Q) while `dir_rx` toggles. This is where the transmit and receive classing differ, and the register lag means the class appears one edge after the count settles. Directed sequences fill the FIFO one sample at a time and drain it again under each direction. Random phases then bias the push and pop rates so that the occupancy drifts across every boundary and reaches full, with rare flips of `dir_rx` and rare clears mixed in.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dir_e;

    typedef enum logic [2:0] {
        LVL_EMPTY = 3'd0,
        LVL_Q1    = 3'd1,
        LVL_Q2    = 3'd2,
        LVL_Q3    = 3'd3,
        LVL_Q4    = 3'd4,
        LVL_FULL  = 3'd5
    } lvl_e;

    typedef struct packed {
        logic push;
        logic pop;
    } xfer_t;

    // Receive classing treats a boundary value as belonging to the band above,
    // which is the same as testing occ+1 against the inclusive transmit limit.
    function automatic lvl_e classify(input int unsigned occ,
                                      input int unsigned depth,
                                      input dir_e        dir);
        int unsigned qtr;
        int unsigned key;
        qtr = depth >> 2;
        key = (dir == DIR_RX) ? occ + 1 : occ;
        if (occ == 0)              return LVL_EMPTY;
        else if (occ >= depth)     return LVL_FULL;
        else if (key <= qtr)       return LVL_Q1;
        else if (key <= 2 * qtr)   return LVL_Q2;
        else if (key <= 3 * qtr)   return LVL_Q3;
        else                       return LVL_Q4;
    endfunction

endpackage

// File: rtl/afifo_store.sv
module afifo_store
    import afifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  xfer_t             xfer,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (xfer.push) wr_ptr <= wr_ptr + 1'b1;
            if (xfer.pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (xfer.push && !clear) mem[wr_ptr] <= wr_data;
    end

    assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/afifo_count.sv
module afifo_count
    import afifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear,
    input  xfer_t                      xfer,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = count;
        if (clear)                      cnt_d = '0;
        else if (xfer.push && !xfer.pop) cnt_d = count + 1'b1;
        else if (xfer.pop && !xfer.push) cnt_d = count - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= cnt_d;
    end

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    // R3: occupancy bounded by the depth
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R1: no write is taken while full
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        full |-> !xfer.push);

    // R4: simultaneous push and pop holds occupancy
    assert_pair_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (xfer.push && xfer.pop && !clear) |=> count == $past(count));

    // R10: clear empties on the next edge
    assert_clear_empty_R10: assert property (@(posedge clk) disable iff (rst)
        clear |=> empty);

endmodule

// File: rtl/afifo_level.sv
module afifo_level
    import afifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clear,
    input  logic [$clog2(DEPTH):0] count,
    input  dir_e                   dir,
    output lvl_e                   level
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    always_ff @(posedge clk) begin
        if (rst || clear) level <= LVL_EMPTY;
        else              level <= classify(32'(count), DEPTH, dir);
    end

    // R9: only codes 0..5 appear
    assert_code_legal_R9: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_FULL);

    // R10: clear forces the empty code
    assert_clear_code_R10: assert property (@(posedge clk) disable iff (rst)
        clear |=> level == LVL_EMPTY);

    // R5: extreme occupancies map to the extreme codes
    assert_full_code_R5: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(DEPTH) && !clear) |=> level == LVL_FULL);
    assert_empty_code_R5: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |=> level == LVL_EMPTY);

endmodule

// File: rtl/audio_fifo_lvl.sv
module audio_fifo_lvl
    import afifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              dir_rx,
    input  logic              push_valid,
    output logic              push_ready,
    input  logic [DATA_W-1:0] push_data,
    output logic              pop_valid,
    input  logic              pop_ready,
    output logic [DATA_W-1:0] pop_data,
    output logic              full,
    output logic              empty,
    output logic [2:0]        level
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
        $error("DEPTH must be a power of two and at least 8");
    end

    xfer_t            xfer;
    logic [CNT_W-1:0] count;
    lvl_e             lvl;

    assign push_ready = !full;
    assign pop_valid  = !empty;
    assign xfer.push  = push_valid && push_ready;
    assign xfer.pop   = pop_valid && pop_ready;
    assign level      = lvl;

    afifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .xfer    (xfer),
        .wr_data (push_data),
        .rd_data (pop_data)
    );

    afifo_count #(.DEPTH(DEPTH)) u_count (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .xfer  (xfer),
        .count (count),
        .full  (full),
        .empty (empty)
    );

    afifo_level #(.DEPTH(DEPTH)) u_level (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .count (count),
        .dir   (dir_e'(dir_rx)),
        .level (lvl)
    );

    // R2: head handshake tracks occupancy
    assert_pop_flag_R2: assert property (@(posedge clk) disable iff (rst)
        pop_valid == !empty);

endmodule

// File: tb/sim_audio_fifo_lvl.sv
module sim_audio_fifo_lvl;
    localparam int DW = 16;
    localparam int D  = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst = 1'b1;
    logic          clear = 1'b0;
    logic          dir_rx = 1'b0;
    logic          push_valid = 1'b0;
    logic          push_ready;
    logic [DW-1:0] push_data = '0;
    logic          pop_valid;
    logic          pop_ready = 1'b0;
    logic [DW-1:0] pop_data;
    logic          full;
    logic          empty;
    logic [2:0]    level;

    audio_fifo_lvl #(.DATA_W(DW), .DEPTH(D)) u0 (
        .clk(clk), .rst(rst), .clear(clear), .dir_rx(dir_rx),
        .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
        .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data),
        .full(full), .empty(empty), .level(level)
    );

    logic [DW-1:0] model [$];
    logic [2:0]    exp_lvl = 3'd0;
    int            errors = 0;
    int            checks = 0;
    bit            done = 0;

    function automatic logic [2:0] ref_code(input int occ, input bit rx);
        if (occ == 0) return 3'd0;
        if (occ == D) return 3'd5;
        if (!rx) begin
            if (occ * 4 <= D)     return 3'd1;
            if (occ * 2 <= D)     return 3'd2;
            if (occ * 4 <= 3 * D) return 3'd3;
            return 3'd4;
        end else begin
            if (occ * 4 < D)      return 3'd1;
            if (occ * 2 < D)      return 3'd2;
            if (occ * 4 < 3 * D)  return 3'd3;
            return 3'd4;
        end
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input bit rx_prev);
        int occ = model.size();
        check("R3 empty", 32'(empty), 32'(occ == 0));
        check("R3 full", 32'(full), 32'(occ == D));
        check("R1 push_ready", 32'(push_ready), 32'(occ != D));
        check("R2 pop_valid", 32'(pop_valid), 32'(occ != 0));
        if (occ != 0) check("R2 pop_data", 32'(pop_data), 32'(model[0]));
        check("R9 legal code", 32'(level <= 3'd5), 32'd1);
        if (exp_lvl == 3'd0 || exp_lvl == 3'd5) check("R5 level", 32'(level), 32'(exp_lvl));
        else if (rx_prev) check("R7 level", 32'(level), 32'(exp_lvl));
        else check("R6 level", 32'(level), 32'(exp_lvl));
    endtask

    // R8: the expected code is the class of the pre-edge occupancy and direction
    task automatic step(input bit pv, input logic [DW-1:0] pd, input bit pr,
                        input bit clr, input bit rx);
        int occ = model.size();
        bit do_push = pv && (occ < D);
        bit do_pop  = pr && (occ > 0);
        push_valid = pv; push_data = pd; pop_ready = pr; clear = clr; dir_rx = rx;
        @(posedge clk);
        if (clr) begin
            exp_lvl = 3'd0;
            model.delete();
        end else begin
            exp_lvl = ref_code(occ, rx);
            if (do_pop)  void'(model.pop_front());
            if (do_push) model.push_back(pd);
        end
        @(negedge clk);
        check_all(rx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_a0d1));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // reset state (R10)
        check("R10 reset empty", 32'(empty), 32'd1);
        check("R10 reset level", 32'(level), 32'd0);

        // R6: transmit fill one at a time, then push while full (R1), then drain
        for (int i = 0; i < D; i++) step(1, DW'(16'h1000 + i), 0, 0, 0);
        step(0, '0, 0, 0, 0);
        step(1, 16'hdead, 0, 0, 0);
        check("R1 ignored push keeps head", 32'(pop_data), 32'h1000);
        for (int i = 0; i < D + 1; i++) step(0, '0, 1, 0, 0);

        // R7: receive fill and drain across each quarter boundary
        for (int i = 0; i < D; i++) step(1, DW'(16'h2000 + i), 0, 0, 1);
        step(0, '0, 0, 0, 1);
        for (int i = 0; i < D + 1; i++) step(0, '0, 1, 0, 1);

        // R4: simultaneous push and pop at occupancy 6
        for (int i = 0; i < 6; i++) step(1, DW'(16'h3000 + i), 0, 0, 0);
        for (int i = 0; i < 4; i++) step(1, DW'(16'h3100 + i), 1, 0, 0);
        step(0, '0, 0, 0, 0);
        check("R4 occupancy held", 32'(level), 32'(ref_code(6, 0)));

        // R10: clear wins over push and pop in the same cycle
        step(1, 16'h4444, 1, 1, 1);
        check("R10 clear empties", 32'(empty), 32'd1);
        check("R10 clear code", 32'(level), 32'd0);
        step(0, '0, 0, 0, 1);

        // random phases with biased rates
        for (int ph = 0; ph < 24; ph++) begin
            int pw = (ph % 3 == 0) ? 85 : (ph % 3 == 1) ? 50 : 20;
            for (int k = 0; k < 150; k++) begin
                bit pv  = ($urandom % 100) < pw;
                bit pr  = ($urandom % 100) < (100 - pw);
                bit clr = ($urandom % 200) == 0;
                bit rx  = ph[1] ^ (($urandom % 40) == 0);
                step(pv, DW'($urandom), pr, clr, rx);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule